// File: doc/BRIEF.md
# BT.656 Timing Code Extractor

This block watches an 8-bit 4:2:2 YCrCb byte stream (one byte per clock, nominally 27 MHz) for the embedded four-byte timing reference codes. Each code is a three-byte preamble of `FF 00 00` followed by a status byte that carries the field flag (F), the vertical blanking flag (V) and the horizontal flag (H), protected by four parity bits. A code arrives right before the active samples of every line (start of active video) and right after them (end of active video). This holds on picture lines and on blanking lines alike.

Decoded flags drive three registered timing pins. H goes to a horizontal sync pin, V to a blank pin and F to a vertical sync pin. For each well-formed code the block pulses a start or an end strobe. A code that fails its protection check raises an error pulse instead and leaves the pins untouched. A counter reports how many active-line bytes have arrived since the last start code.

The sync hunter is a four-state machine:
- **HUNT** moves to SEEN_FF on `FF` and otherwise stays.
- **SEEN_FF** moves to SEEN_Z1 on `00`, stays on `FF`, and otherwise returns to HUNT.
- **SEEN_Z1** moves to SEEN_Z2 on `00`, returns to SEEN_FF on `FF`, and otherwise returns to HUNT.
- **SEEN_Z2** takes whatever byte arrives as the status byte and always returns to HUNT.

Top module: `bt656_timing_extract`

## Requirements
- R1: After reset, hsync_o=1, blank_o=1, vsync_o=0, sav_o=eav_o=code_err_o=0 and act_count_o=0.
- R2: A code is recognised only after the bytes FF, 00, 00 arrive on consecutive cycles. A non-matching byte after FF or after FF 00 abandons the match. An FF at either of those points starts a new match.
- R3: The byte following FF 00 00 is always consumed as the status byte, even when it is FF. The hunt then restarts with the next byte.
- R4: The status byte is laid out MSB to LSB as 1, F, V, H, P3, P2, P1, P0. On a valid status byte, vsync_o takes F, blank_o takes V and hsync_o takes H. All three change at the same clock edge that captures the status byte.
- R5: A valid status byte with H=0 gives a one-cycle sav_o pulse. A valid status byte with H=1 gives a one-cycle eav_o pulse. Both pulses appear at the same edge as the pin update.
- R6: A status byte is valid only if bit 7 is 1, P3=V^H, P2=F^H, P1=F^V and P0=F^V^H. Otherwise code_err_o pulses for one cycle, sav_o and eav_o stay low, and hsync_o, blank_o, vsync_o and act_count_o keep their values.
- R7: A valid start code clears act_count_o to 0. Until the next valid end code, act_count_o then rises by one for every byte that arrives while the hunter is in HUNT and is not FF. The count holds after a valid end code and saturates at 2^CNT_W-1.
- R8: At most one of sav_o, eav_o and code_err_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_byte | input | 8 | Incoming video byte |
| hsync_o | output | 1 | Last valid H flag |
| blank_o | output | 1 | Last valid V flag |
| vsync_o | output | 1 | Last valid F flag |
| sav_o | output | 1 | Pulse: valid start-of-active-video code |
| eav_o | output | 1 | Pulse: valid end-of-active-video code |
| code_err_o | output | 1 | Pulse: status byte failed protection check |
| act_count_o | output | CNT_W | Active-line byte count since last start code |

## Verification
A hunter left in the wrong state shows up as a missed or phantom code. The pins, the strobes or the byte count then disagree with the reference model at the very edge where the status byte is, or should have been, captured. A wrong protection check flips the pins or the error pulse in that same cycle.

A counter gating fault surfaces one cycle after the first mis-counted byte. The counter holds its value, so the mismatch also persists until the next start code. The bench therefore compares every output on every clock against a behavioural model, across directed corner cases and a long pseudo-random stream.

// File: rtl/bt656x_pkg.sv
package bt656x_pkg;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_SEEN_FF = 2'd1,
        ST_SEEN_Z1 = 2'd2,
        ST_SEEN_Z2 = 2'd3
    } hunt_state_t;

    typedef struct packed {
        logic f;
        logic v;
        logic h;
    } tflags_t;

    localparam logic [7:0] PRE_HI = 8'hFF;
    localparam logic [7:0] PRE_LO = 8'h00;

    function automatic logic status_valid(input logic [7:0] s);
        logic f, v, h;
        f = s[6];
        v = s[5];
        h = s[4];
        return s[7] && (s[3] == (v ^ h)) && (s[2] == (f ^ h)) &&
               (s[1] == (f ^ v)) && (s[0] == (f ^ v ^ h));
    endfunction

endpackage

// File: rtl/bt656x_hunt.sv
module bt656x_hunt
    import bt656x_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] din,
    output logic       status_stb,
    output logic       data_en
);
    hunt_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT:    state_d = (din == PRE_HI) ? ST_SEEN_FF : ST_HUNT;
            ST_SEEN_FF: begin
                if (din == PRE_LO)      state_d = ST_SEEN_Z1;
                else if (din == PRE_HI) state_d = ST_SEEN_FF;
                else                    state_d = ST_HUNT;
            end
            ST_SEEN_Z1: begin
                if (din == PRE_LO)      state_d = ST_SEEN_Z2;
                else if (din == PRE_HI) state_d = ST_SEEN_FF;
                else                    state_d = ST_HUNT;
            end
            ST_SEEN_Z2: state_d = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    always_comb begin
        status_stb = 1'b0;
        data_en    = 1'b0;
        unique case (state_q)
            ST_HUNT:    data_en    = (din != PRE_HI);
            ST_SEEN_FF: ;
            ST_SEEN_Z1: ;
            ST_SEEN_Z2: status_stb = 1'b1;
        endcase
    end

    // R2: the status state is reached only straight after the second zero
    a_r2_preamble_order: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEEN_Z2) |-> ($past(state_q) == ST_SEEN_Z1 && $past(din) == PRE_LO));

    // R3: the status byte is always consumed and the hunt restarts
    a_r3_status_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEEN_Z2) |=> (state_q == ST_HUNT));
endmodule

// File: rtl/bt656x_flags.sv
module bt656x_flags
    import bt656x_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       status_stb,
    input  logic [7:0] status,
    output tflags_t    flags_o,
    output logic       sav_o,
    output logic       eav_o,
    output logic       err_o
);
    logic good;
    assign good = status_valid(status);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_o <= '{f: 1'b0, v: 1'b1, h: 1'b1};
            sav_o   <= 1'b0;
            eav_o   <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            sav_o <= status_stb && good && !status[4];
            eav_o <= status_stb && good &&  status[4];
            err_o <= status_stb && !good;
            if (status_stb && good)
                flags_o <= '{f: status[6], v: status[5], h: status[4]};
        end
    end

    // R8: strobes never overlap
    a_r8_onehot_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sav_o, eav_o, err_o}));

    // R6: a rejected code leaves the timing pins alone
    a_r6_hold_on_error: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $stable(flags_o));

    // R5: the strobe agrees with the horizontal pin
    a_r5_sav_h_low: assert property (@(posedge clk) disable iff (!rst_n)
        sav_o |-> !flags_o.h);
    a_r5_eav_h_high: assert property (@(posedge clk) disable iff (!rst_n)
        eav_o |-> flags_o.h);
endmodule

// File: rtl/bt656x_count.sv
module bt656x_count #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             byte_en,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic active_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_o    <= '0;
        end else if (start_i) begin
            active_q <= 1'b1;
            cnt_o    <= '0;
        end else if (stop_i) begin
            active_q <= 1'b0;
        end else if (active_q && byte_en && cnt_o != CNT_MAX) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

    // R7: without a start code the count never goes down
    a_r7_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (cnt_o >= $past(cnt_o)));

    // R7: an end code freezes the count
    a_r7_hold_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> $stable(cnt_o));
endmodule

// File: rtl/bt656_timing_extract.sv
module bt656_timing_extract
    import bt656x_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       vid_byte,
    output logic             hsync_o,
    output logic             blank_o,
    output logic             vsync_o,
    output logic             sav_o,
    output logic             eav_o,
    output logic             code_err_o,
    output logic [CNT_W-1:0] act_count_o
);
    logic    status_stb, data_en;
    logic    good_code, start_evt, stop_evt;
    tflags_t flags;

    bt656x_hunt u_hunt (
        .clk        (clk),
        .rst_n      (rst_n),
        .din        (vid_byte),
        .status_stb (status_stb),
        .data_en    (data_en)
    );

    bt656x_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .status_stb (status_stb),
        .status     (vid_byte),
        .flags_o    (flags),
        .sav_o      (sav_o),
        .eav_o      (eav_o),
        .err_o      (code_err_o)
    );

    assign good_code = status_stb && status_valid(vid_byte);
    assign start_evt = good_code && !vid_byte[4];
    assign stop_evt  = good_code &&  vid_byte[4];

    bt656x_count #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_evt),
        .stop_i  (stop_evt),
        .byte_en (data_en),
        .cnt_o   (act_count_o)
    );

    assign hsync_o = flags.h;
    assign blank_o = flags.v;
    assign vsync_o = flags.f;

    // R4: pins move only at the edge that captures a valid code
    a_r4_pins_move_on_code: assert property (@(posedge clk) disable iff (!rst_n)
        !(sav_o || eav_o) |-> $stable({hsync_o, blank_o, vsync_o}));
endmodule

// File: tb/bt656_timing_extract_test.sv
module bt656_timing_extract_test;
    localparam int CW = 12;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] vid_byte = 8'h10;
    logic hsync_o, blank_o, vsync_o, sav_o, eav_o, code_err_o;
    logic [CW-1:0] act_count_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // reference model state
    int prog = 0;
    bit m_f = 0, m_v = 1, m_h = 1, m_act = 0;
    bit m_sav = 0, m_eav = 0, m_err = 0;
    int m_cnt = 0;

    always #4 clk = ~clk;

    bt656_timing_extract #(.CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .vid_byte(vid_byte),
        .hsync_o(hsync_o), .blank_o(blank_o), .vsync_o(vsync_o),
        .sav_o(sav_o), .eav_o(eav_o), .code_err_o(code_err_o),
        .act_count_o(act_count_o)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [7:0] mk_code(input bit f, input bit v, input bit h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    function automatic bit code_ok(input logic [7:0] s);
        return s == mk_code(s[6], s[5], s[4]);
    endfunction

    task automatic model_step(input logic [7:0] b);
        m_sav = 0; m_eav = 0; m_err = 0;
        if (prog == 3) begin
            prog = 0;
            if (code_ok(b)) begin
                m_f = b[6]; m_v = b[5]; m_h = b[4];
                if (!b[4]) begin m_sav = 1; m_act = 1; m_cnt = 0; end
                else begin m_eav = 1; m_act = 0; end
            end else m_err = 1;
        end else if (prog == 0) begin
            if (b == 8'hFF) prog = 1;
            else if (m_act && m_cnt < CMAX) m_cnt++;
        end else if (prog == 1) begin
            prog = (b == 8'h00) ? 2 : (b == 8'hFF) ? 1 : 0;
        end else begin
            prog = (b == 8'h00) ? 3 : (b == 8'hFF) ? 1 : 0;
        end
    endtask

    task automatic compare_all();
        chk("R4 hsync", hsync_o, m_h);
        chk("R4 blank", blank_o, m_v);
        chk("R4 vsync", vsync_o, m_f);
        chk("R5 sav", sav_o, m_sav);
        chk("R5 eav", eav_o, m_eav);
        chk("R6 err", code_err_o, m_err);
        chk("R7 count", act_count_o, m_cnt);
        chk("R8 onehot", int'(sav_o) + int'(eav_o) + int'(code_err_o) <= 1, 1);
    endtask

    task automatic push(input logic [7:0] b);
        vid_byte = b;
        model_step(b);
        @(posedge clk);
        #1;
        compare_all();
    endtask

    task automatic send_code(input logic [7:0] s);
        push(8'hFF); push(8'h00); push(8'h00); push(s);
    endtask

    task automatic send_data(input int n, input int seed);
        for (int i = 0; i < n; i++) push(8'((seed + i * 7) % 254 + 1));
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int lf;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset values
        chk("R1 hsync", hsync_o, 1); chk("R1 blank", blank_o, 1);
        chk("R1 vsync", vsync_o, 0); chk("R1 strobes", {sav_o, eav_o, code_err_o}, 0);
        chk("R1 count", act_count_o, 0);
        rst_n = 1'b1;
        // active line: start, 10 bytes, end
        send_code(mk_code(0, 0, 0));
        chk("R5 sav seen", sav_o, 1);
        send_data(10, 3);
        send_code(mk_code(0, 0, 1));
        chk("R7 line length", act_count_o, 10);
        send_data(5, 9);
        chk("R7 held after end", act_count_o, 10);
        // blanking and field codes
        send_code(mk_code(1, 1, 0));
        chk("R4 vsync high", vsync_o, 1);
        send_data(4, 1);
        send_code(mk_code(1, 1, 1));
        // parity failure and bit7 clear: R6
        send_code(mk_code(0, 0, 0) ^ 8'h04);
        chk("R6 err pulse", code_err_o, 1);
        send_code(mk_code(0, 1, 0) & 8'h7F);
        chk("R6 bit7 error", code_err_o, 1);
        chk("R6 held vsync", vsync_o, 1);
        // R2: broken preambles, FF restart
        push(8'hFF); push(8'h00); push(8'h55); push(mk_code(0, 0, 0));
        chk("R2 no false code", sav_o, 0);
        push(8'hFF); push(8'hFF); push(8'h00); push(8'h00); push(mk_code(0, 0, 0));
        chk("R2 restart detects", sav_o, 1);
        // R3: FF in the status slot is consumed, no restart
        push(8'hFF); push(8'h00); push(8'h00); push(8'hFF);
        chk("R3 ff status error", code_err_o, 1);
        push(8'h00); push(8'h00); push(mk_code(0, 1, 1));
        chk("R3 no restart", eav_o, 0);
        // R7 saturation
        send_code(mk_code(0, 0, 0));
        send_data(CMAX + 20, 5);
        chk("R7 saturated", act_count_o, CMAX);
        send_code(mk_code(0, 0, 1));
        // pseudo-random stream
        lf = 32'h1ACE;
        for (int i = 0; i < 6000; i++) begin
            lf = (lf >> 1) ^ ((lf & 1) ? 32'hB400 : 0);
            if ((lf & 63) == 5) begin
                logic [7:0] c;
                c = mk_code(lf[8], lf[9], lf[10]);
                if ((lf & 448) == 64) c = c ^ 8'h01;
                send_code(c);
            end else if ((lf & 255) == 17) begin
                push(8'hFF); push(8'h00);
            end else begin
                push(8'(lf[15:8] == 8'hFF ? 8'hFE : lf[15:8]));
            end
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule